// File: doc/BRIEF.md
# Pipeline Memory and Writeback Stage

This block is the stage of a simple processor pipeline that either writes a computed result straight into the register file or performs a data-memory load or store. The previous stage hands over one operation at a time through a submit pulse, and the operation is accepted only while the stage reports ready. Each operation carries an address, a data word, a one-hot destination mask, a flag marking a memory operation and a flag marking a store.

A register-only operation appears on the register write port one cycle after it is accepted, and the stage stays ready. A memory operation is turned into a request on the memory port. That request stays up with stable fields until the memory acknowledges it, which may take any number of cycles, including zero extra ones. While it waits, the stage holds ready low. When a load completes, the returned word is written to the destination register. A store never writes a register.

Top module: `mem_wb_stage`

## Requirements
- R1: While reset is held high at a clock edge (synchronous, active-high), the stage leaves that edge with ready high, no memory request and an all-zero register write mask.
- R2: An operation is taken only at a clock edge where submit and ready are both high. A submit while ready is low is dropped: it changes neither the pending request's address, data or write flag, nor the writes that follow.
- R3: A register-only operation (memory flag 0) with a non-zero mask drives that mask and its data on the register write port for exactly the one cycle after acceptance. It raises no memory request, and ready stays high.
- R4: A register-only operation with an all-zero mask causes no register write and no memory request, and ready stays high.
- R5: A store (memory flag 1, store flag 1) raises the memory request with write flag 1 and the submitted address and data. It never produces a non-zero register write mask, whatever destination mask was given.
- R6: A load (memory flag 1, store flag 0) raises the memory request with write flag 0. In the cycle after the acknowledge is sampled, the destination mask and the memory read data captured at that acknowledge edge appear on the register write port for exactly one cycle.
- R7: From the cycle after acceptance, the memory request stays high and its address, data and write flag stay unchanged until an edge where the acknowledge is sampled high.
- R8: Ready is low from the cycle after a memory operation is accepted until the acknowledge edge, and it is high again, with the request low, in the following cycle.
- R9: An acknowledge that is already high in the first cycle the request is visible completes the operation at that edge.
- R10: An acknowledge pulse while no request is pending has no effect: no register write, no request, and ready stays high.
- R11: In the register write mask, bit N selects destination register N. The mask holds at most one set bit, and it is all zero except in write cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_valid | input | 1 | Single-cycle submit pulse from the previous stage |
| up_ready | output | 1 | Stage can accept an operation |
| up_addr | input | ADDR_W | Memory address of the operation |
| up_wdata | input | DATA_W | Result to write back, or store data |
| up_rd_mask | input | NUM_REGS | One-hot destination register mask |
| up_is_mem | input | 1 | Operation accesses memory |
| up_is_store | input | 1 | Memory operation is a store (else a load) |
| mem_req | output | 1 | Memory request pending |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Request address |
| mem_wdata | output | DATA_W | Request write data |
| mem_ack | input | 1 | Single-cycle acknowledge from memory |
| mem_rdata | input | DATA_W | Load data, valid with the acknowledge |
| rf_we_mask | output | NUM_REGS | One-hot register write enable |
| rf_wdata | output | DATA_W | Register write data |

## Verification
The bench runs loads and stores with an acknowledge that arrives in the very first request cycle and after several wait cycles. A stage that waits one extra cycle before completing would leave the request up, and one that finishes early would drop the request before the acknowledge. Stores are given a non-zero destination mask, so a design that forgets to suppress the write would pulse the register port. A submit during a pending request and a stray acknowledge while idle are also driven: a design that lets either through would change the pending address, start a phantom operation or write a register.

// File: rtl/mem_wb_stage.sv
module mem_wb_stage #(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 16,
  parameter int NUM_REGS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                up_valid,
  output logic                up_ready,
  input  logic [ADDR_W-1:0]   up_addr,
  input  logic [DATA_W-1:0]   up_wdata,
  input  logic [NUM_REGS-1:0] up_rd_mask,
  input  logic                up_is_mem,
  input  logic                up_is_store,
  output logic                mem_req,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic                mem_ack,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic [NUM_REGS-1:0] rf_we_mask,
  output logic [DATA_W-1:0]   rf_wdata
);

  logic                busy;
  logic                op_we;
  logic [ADDR_W-1:0]   op_addr;
  logic [DATA_W-1:0]   op_data;
  logic [NUM_REGS-1:0] op_dest;
  logic [NUM_REGS-1:0] wb_mask;
  logic [DATA_W-1:0]   wb_data;
  logic                take;
  logic                done;

  assign take = up_valid & ~busy;
  assign done = busy & mem_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      op_we   <= 1'b0;
      op_addr <= '0;
      op_data <= '0;
      op_dest <= '0;
      wb_mask <= '0;
      wb_data <= '0;
    end else begin
      wb_mask <= '0;
      if (take) begin
        if (up_is_mem) begin
          busy    <= 1'b1;
          op_we   <= up_is_store;
          op_addr <= up_addr;
          op_data <= up_wdata;
          op_dest <= up_is_store ? '0 : up_rd_mask;
        end else begin
          wb_mask <= up_rd_mask;
          wb_data <= up_wdata;
        end
      end else if (done) begin
        busy    <= 1'b0;
        wb_mask <= op_dest;
        if (!op_we) wb_data <= mem_rdata;
      end
    end
  end

  assign up_ready   = ~busy;
  assign mem_req    = busy;
  assign mem_we     = op_we;
  assign mem_addr   = op_addr;
  assign mem_wdata  = op_data;
  assign rf_we_mask = wb_mask;
  assign rf_wdata   = wb_data;

endmodule

// File: rtl/mem_wb_stage_chk.sv
module mem_wb_stage_chk #(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 16,
  parameter int NUM_REGS = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                up_valid,
  input logic                up_ready,
  input logic [ADDR_W-1:0]   up_addr,
  input logic [DATA_W-1:0]   up_wdata,
  input logic [NUM_REGS-1:0] up_rd_mask,
  input logic                up_is_mem,
  input logic                up_is_store,
  input logic                mem_req,
  input logic                mem_we,
  input logic [ADDR_W-1:0]   mem_addr,
  input logic [DATA_W-1:0]   mem_wdata,
  input logic                mem_ack,
  input logic [DATA_W-1:0]   mem_rdata,
  input logic [NUM_REGS-1:0] rf_we_mask,
  input logic [DATA_W-1:0]   rf_wdata
);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_we)); // R7

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !up_ready); // R8

  AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_ack |=> !mem_req && up_ready); // R8

  AST_STORE_NO_WB: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we && mem_ack |=> rf_we_mask == '0); // R5

  AST_LOAD_WB: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_we && mem_ack |=> rf_wdata == $past(mem_rdata)); // R6

  AST_REG_OP_WB: assert property (@(posedge clk) disable iff (rst)
    up_valid && up_ready && !up_is_mem |=> !mem_req && up_ready &&
      rf_we_mask == $past(up_rd_mask)); // R3

  AST_IDLE_ACK_QUIET: assert property (@(posedge clk) disable iff (rst)
    !mem_req && !(up_valid && up_ready) |=> rf_we_mask == '0 && !mem_req); // R10

  AST_MASK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rf_we_mask)); // R11

endmodule

bind mem_wb_stage mem_wb_stage_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)
) u_chk (
  .clk(clk), .rst(rst), .up_valid(up_valid), .up_ready(up_ready),
  .up_addr(up_addr), .up_wdata(up_wdata), .up_rd_mask(up_rd_mask),
  .up_is_mem(up_is_mem), .up_is_store(up_is_store), .mem_req(mem_req),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_ack(mem_ack), .mem_rdata(mem_rdata), .rf_we_mask(rf_we_mask),
  .rf_wdata(rf_wdata)
);

// File: tb/mem_wb_stage_tb.sv
`timescale 1ns/1ps
module mem_wb_stage_tb;
  localparam int DW = 16;
  localparam int AW = 16;
  localparam int NR = 8;

  logic clk = 1'b0;
  logic rst;
  logic up_valid, up_ready, up_is_mem, up_is_store;
  logic [AW-1:0] up_addr;
  logic [DW-1:0] up_wdata;
  logic [NR-1:0] up_rd_mask;
  logic mem_req, mem_we, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic [NR-1:0] rf_we_mask;
  logic [DW-1:0] rf_wdata;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  mem_wb_stage #(.DATA_W(DW), .ADDR_W(AW), .NUM_REGS(NR)) u_dut (
    .clk(clk), .rst(rst), .up_valid(up_valid), .up_ready(up_ready),
    .up_addr(up_addr), .up_wdata(up_wdata), .up_rd_mask(up_rd_mask),
    .up_is_mem(up_is_mem), .up_is_store(up_is_store), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .rf_we_mask(rf_we_mask),
    .rf_wdata(rf_wdata)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic submit(input logic [AW-1:0] a, input logic [DW-1:0] d, input int reg_n,
                        input logic use_mask, input logic is_mem, input logic is_st);
    @(negedge clk);
    up_valid    = 1'b1;
    up_addr     = a;
    up_wdata    = d;
    up_rd_mask  = use_mask ? NR'(1 << reg_n) : '0;
    up_is_mem   = is_mem;
    up_is_store = is_st;
    tick();
    up_valid = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    up_valid = 0; up_addr = '0; up_wdata = '0; up_rd_mask = '0;
    up_is_mem = 0; up_is_store = 0; mem_ack = 0; mem_rdata = '0;
    repeat (3) tick();
    chk("R1", "ready", up_ready, 1);
    chk("R1", "mem_req", mem_req, 0);
    chk("R1", "rf_we_mask", rf_we_mask, 0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reg_write(input int reg_n, input logic [DW-1:0] d);
    submit(16'h0, d, reg_n, 1'b1, 1'b0, 1'b0);
    chk("R3", "rf_we_mask", rf_we_mask, 64'(1) << reg_n);
    chk("R11", "onehot bit", rf_we_mask[reg_n], 1);
    chk("R3", "rf_wdata", rf_wdata, d);
    chk("R3", "mem_req", mem_req, 0);
    chk("R3", "ready", up_ready, 1);
    tick();
    chk("R11", "mask cleared", rf_we_mask, 0);
  endtask

  task automatic t_reg_nowrite;
    submit(16'h5, 16'hBEEF, 0, 1'b0, 1'b0, 1'b0);
    chk("R4", "rf_we_mask", rf_we_mask, 0);
    chk("R4", "mem_req", mem_req, 0);
    chk("R4", "ready", up_ready, 1);
  endtask

  task automatic t_mem(input string req, input logic is_st, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input int reg_n, input int wait_n,
                       input logic [DW-1:0] rdata, input logic poke);
    submit(a, d, reg_n, 1'b1, 1'b1, is_st);
    chk(req, "mem_req", mem_req, 1);
    chk(req, "mem_we", mem_we, is_st);
    chk(req, "mem_addr", mem_addr, a);
    if (is_st) chk("R5", "mem_wdata", mem_wdata, d);
    chk("R8", "ready low", up_ready, 0);
    chk(req, "no early wb", rf_we_mask, 0);
    for (int i = 0; i < wait_n; i++) begin
      if (poke && i == 0) begin
        @(negedge clk);
        up_valid = 1'b1; up_addr = ~a; up_wdata = ~d; up_is_mem = 1'b1; up_is_store = ~is_st;
        tick();
        up_valid = 1'b0;
        chk("R2", "addr kept", mem_addr, a);
        chk("R2", "we kept", mem_we, is_st);
      end else begin
        tick();
        chk("R7", "req held", mem_req, 1);
        chk("R7", "addr held", mem_addr, a);
      end
      chk("R8", "ready still low", up_ready, 0);
    end
    @(negedge clk);
    mem_ack = 1'b1;
    mem_rdata = rdata;
    tick();
    mem_ack = 1'b0;
    mem_rdata = ~rdata;
    chk("R8", "req dropped", mem_req, 0);
    chk("R8", "ready back", up_ready, 1);
    if (is_st) begin
      chk("R5", "no store wb", rf_we_mask, 0);
    end else begin
      chk("R6", "load mask", rf_we_mask, 64'(1) << reg_n);
      chk("R6", "load data", rf_wdata, rdata);
    end
    tick();
    chk(req, "wb one cycle", rf_we_mask, 0);
    chk(req, "no phantom req", mem_req, 0);
  endtask

  task automatic t_stray_ack;
    @(negedge clk);
    mem_ack = 1'b1;
    mem_rdata = 16'h1234;
    tick();
    mem_ack = 1'b0;
    chk("R10", "rf_we_mask", rf_we_mask, 0);
    chk("R10", "mem_req", mem_req, 0);
    chk("R10", "ready", up_ready, 1);
  endtask

  initial begin
    t_reset();
    t_reg_write(3, 16'h0001);
    t_reg_write(7, 16'hA5A5);
    t_reg_write(0, 16'hFFFF);
    t_reg_nowrite();
    t_mem("R5", 1'b1, 16'h000A, 16'h4321, 2, 0, 16'h0, 1'b0);
    t_mem("R6", 1'b0, 16'h000A, 16'h0000, 2, 0, 16'h4321, 1'b0);
    t_mem("R9", 1'b0, 16'h0040, 16'h0000, 5, 0, 16'h8001, 1'b0);
    t_mem("R5", 1'b1, 16'h1000, 16'h7E7E, 4, 3, 16'h0, 1'b0);
    t_mem("R6", 1'b0, 16'h2002, 16'h0000, 6, 4, 16'hC3C3, 1'b1);
    t_mem("R2", 1'b1, 16'h3003, 16'h5555, 1, 2, 16'h0, 1'b1);
    t_stray_ack();
    t_reg_write(1, 16'h00F0);
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #50000;
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule